// File: doc/BRIEF.md
# Boot ROM Region Decoder

This block sits on the host memory cycle path and decides, cycle by cycle, whether an access falls into the boot ROM space. When it does, the block claims the access and opens an external memory cycle by driving an active-low ROM chip select together with the matching read or write strobe. A bus sequencer runs the cycle itself and reports completion with a one-cycle done pulse. Then the block drops every strobe together and goes back to watching for the next access.

Two address windows are decoded: a low window just below the 1 MB line and a high window at the top of the 32-bit space. A configuration bit widens both. The ROM data width (8 or 16 bits) is taken from a strap on the first clock edge after reset, and software can override it later. Writes to the ROM space are dropped unless a flash-write enable is set. With that enable set, a write runs as a full write cycle with chip select asserted.

Top module: `romRegionDecoder`

## Requirements
- R1: While `rstN` is low at a clock edge, `romCsN`, `memRdN`, `memWrN` and `wrN` are 1 after that edge, and `claim` and `width16` are 0.
- R2: With `cfgBigWindow` = 0, an access is in the ROM space exactly when its address lies in 0x000F0000..0x000FFFFF or in 0xFFFC0000..0xFFFFFFFF.
- R3: With `cfgBigWindow` = 1, the ROM space is 0x000E0000..0x000FFFFF together with 0xFF000000..0xFFFFFFFF.
- R4: A read (`cycWrite` = 0) with `cycValid` = 1 in the ROM space, sampled while idle, gives `claim` = 1 for exactly one cycle after that edge. From the same edge, `romCsN` = 0 and `memRdN` = 0, while `memWrN` and `wrN` stay at 1.
- R5: A write to the ROM space with `cfgFlashWrEn` = 0 is not claimed. `claim` stays 0 and all four strobes stay at 1.
- R6: A write to the ROM space with `cfgFlashWrEn` = 1 gives a one-cycle `claim`. `romCsN`, `memWrN` and `wrN` go to 0 together, and `memRdN` stays at 1.
- R7: An access outside the active ROM space, or any cycle with `cycValid` = 0, leaves `claim` at 0 and all strobes at 1.
- R8: Once asserted, the strobes keep their values until `busDone` = 1 is sampled. After that edge, all four are 1. A `busDone` pulse while idle has no effect.
- R9: While a ROM cycle is open, new `cycValid` accesses are ignored. `claim` stays 0 and the strobes do not change.
- R10: `width16` takes the value of `strapWide16` sampled on the first edge after reset is released, while `cfgWidthOvrEn` = 0. Later changes of `strapWide16` have no effect until the next reset.
- R11: With `cfgWidthOvrEn` = 1, `width16` follows `cfgWidthOvr16` one edge later. After `cfgWidthOvrEn` is cleared, `width16` returns to the captured strap value one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cycValid | input | 1 | Host memory cycle present this clock |
| cycAddr | input | 32 | Host memory address |
| cycWrite | input | 1 | 1 = write, 0 = read |
| strapWide16 | input | 1 | Width strap, 1 = 16-bit ROM |
| cfgBigWindow | input | 1 | Selects the larger pair of windows |
| cfgWidthOvrEn | input | 1 | Enables the software width override |
| cfgWidthOvr16 | input | 1 | Override width, 1 = 16-bit |
| cfgFlashWrEn | input | 1 | Lets ROM writes through as write cycles |
| busDone | input | 1 | Bus sequencer finished the open cycle |
| claim | output | 1 | One-cycle pulse: access taken as ROM |
| romCsN | output | 1 | ROM chip select, active low |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| wrN | output | 1 | Generic write strobe, active low |
| width16 | output | 1 | Selected data width, 1 = 16-bit |

## Verification
Two functions can meet on the same clock: a new host access arriving while a ROM cycle is still open, and the `busDone` that closes that cycle. The bench provokes the first case by issuing a second ROM access, of the other direction, while a read is held open. It checks that `claim` stays low and that the strobes, including the write strobe, do not move. It then releases the cycle with `busDone` and checks that all strobes rise together on the following edge, with no new cycle opened by the ignored access. The address and operation sweeps judge each result against windows computed arithmetically in the bench.

// File: rtl/romDecodePkg.sv
package romDecodePkg;

  // Control -> datapath strobes for one clock
  typedef struct packed {
    logic startRd;   // open a ROM read cycle
    logic startWr;   // open a ROM write cycle
    logic dropAll;   // close the open cycle
    logic claimNow;  // pulse the claim flag
  } romStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } romState_t;

endpackage

// File: rtl/romWindowMatch.sv
module romWindowMatch #(
  parameter int addrW = 32,
  parameter logic [addrW-1:0] endAddr = '1,
  parameter int narrowLog = 16,
  parameter int wideLog = 17
) (
  input  logic [addrW-1:0] addr,
  input  logic             wide,
  output logic             hit
);
  // The window ends at endAddr and is 2**log bytes, so an upper-bit compare is enough
  localparam int narrowTagW = addrW - narrowLog;
  localparam int wideTagW   = addrW - wideLog;

  logic narrowHit, wideHit;

  assign narrowHit = (addr[addrW-1:narrowLog] == endAddr[addrW-1:narrowLog]);
  assign wideHit   = (addr[addrW-1:wideLog]   == endAddr[addrW-1:wideLog]);
  assign hit       = wide ? wideHit : narrowHit;

  logic unusedTags;
  assign unusedTags = ^{narrowTagW[0], wideTagW[0]};
endmodule

// File: rtl/romDecodeDatapath.sv
module romDecodeDatapath
  import romDecodePkg::*;
#(
  parameter int addrW = 32,
  parameter logic [addrW-1:0] lowEnd = 32'h000F_FFFF,
  parameter logic [addrW-1:0] highEnd = 32'hFFFF_FFFF,
  parameter int lowNarrowLog = 16,
  parameter int lowWideLog = 17,
  parameter int highNarrowLog = 18,
  parameter int highWideLog = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [addrW-1:0] cycAddr,
  input  logic             cfgBigWindow,
  input  logic             strapWide16,
  input  logic             cfgWidthOvrEn,
  input  logic             cfgWidthOvr16,
  input  romStrobes_t      strobes,
  output logic             romHit,
  output logic             claim,
  output logic             romCsN,
  output logic             memRdN,
  output logic             memWrN,
  output logic             wrN,
  output logic             width16
);
  localparam int numWin = 2;
  localparam logic [addrW-1:0] winEnd [numWin] = '{lowEnd, highEnd};
  localparam int winNarrow [numWin] = '{lowNarrowLog, highNarrowLog};
  localparam int winWide   [numWin] = '{lowWideLog, highWideLog};

  logic [numWin-1:0] winHit;

  for (genvar w = 0; w < numWin; w++) begin : gWin
    romWindowMatch #(
      .addrW(addrW),
      .endAddr(winEnd[w]),
      .narrowLog(winNarrow[w]),
      .wideLog(winWide[w])
    ) uMatch (
      .addr(cycAddr),
      .wide(cfgBigWindow),
      .hit(winHit[w])
    );
  end

  assign romHit = |winHit;

  // Strobe registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      claim  <= 1'b0;
      romCsN <= 1'b1;
      memRdN <= 1'b1;
      memWrN <= 1'b1;
      wrN    <= 1'b1;
    end else begin
      claim <= strobes.claimNow;
      if (strobes.dropAll) begin
        romCsN <= 1'b1;
        memRdN <= 1'b1;
        memWrN <= 1'b1;
        wrN    <= 1'b1;
      end else if (strobes.startRd) begin
        romCsN <= 1'b0;
        memRdN <= 1'b0;
      end else if (strobes.startWr) begin
        romCsN <= 1'b0;
        memWrN <= 1'b0;
        wrN    <= 1'b0;
      end
    end
  end

  // Width: strap taken on the first edge out of reset, then optionally overridden
  logic strapSeen, strapHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strapSeen <= 1'b0;
      strapHeld <= 1'b0;
      width16   <= 1'b0;
    end else begin
      if (!strapSeen) begin
        strapSeen <= 1'b1;
        strapHeld <= strapWide16;
      end
      if (cfgWidthOvrEn)
        width16 <= cfgWidthOvr16;
      else if (strapSeen)
        width16 <= strapHeld;
      else
        width16 <= strapWide16;
    end
  end
endmodule

// File: rtl/romDecodeControl.sv
module romDecodeControl
  import romDecodePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycValid,
  input  logic        cycWrite,
  input  logic        romHit,
  input  logic        cfgFlashWrEn,
  input  logic        busDone,
  output romStrobes_t strobes
);
  romState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cycValid && romHit) begin
          if (!cycWrite) begin
            strobes.startRd  = 1'b1;
            strobes.claimNow = 1'b1;
            stateNext        = ST_OPEN;
          end else if (cfgFlashWrEn) begin
            strobes.startWr  = 1'b1;
            strobes.claimNow = 1'b1;
            stateNext        = ST_OPEN;
          end
        end
      end
      ST_OPEN: begin
        if (busDone) begin
          strobes.dropAll = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/romRegionDecoder.sv
module romRegionDecoder
  import romDecodePkg::*;
#(
  parameter int addrW = 32,
  parameter logic [addrW-1:0] lowEnd = 32'h000F_FFFF,
  parameter logic [addrW-1:0] highEnd = 32'hFFFF_FFFF,
  parameter int lowNarrowLog = 16,
  parameter int lowWideLog = 17,
  parameter int highNarrowLog = 18,
  parameter int highWideLog = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycValid,
  input  logic [addrW-1:0] cycAddr,
  input  logic             cycWrite,
  input  logic             strapWide16,
  input  logic             cfgBigWindow,
  input  logic             cfgWidthOvrEn,
  input  logic             cfgWidthOvr16,
  input  logic             cfgFlashWrEn,
  input  logic             busDone,
  output logic             claim,
  output logic             romCsN,
  output logic             memRdN,
  output logic             memWrN,
  output logic             wrN,
  output logic             width16
);
  romStrobes_t strobes;
  logic        romHit;

  romDecodeControl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .cycValid(cycValid),
    .cycWrite(cycWrite),
    .romHit(romHit),
    .cfgFlashWrEn(cfgFlashWrEn),
    .busDone(busDone),
    .strobes(strobes)
  );

  romDecodeDatapath #(
    .addrW(addrW),
    .lowEnd(lowEnd),
    .highEnd(highEnd),
    .lowNarrowLog(lowNarrowLog),
    .lowWideLog(lowWideLog),
    .highNarrowLog(highNarrowLog),
    .highWideLog(highWideLog)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .cycAddr(cycAddr),
    .cfgBigWindow(cfgBigWindow),
    .strapWide16(strapWide16),
    .cfgWidthOvrEn(cfgWidthOvrEn),
    .cfgWidthOvr16(cfgWidthOvr16),
    .strobes(strobes),
    .romHit(romHit),
    .claim(claim),
    .romCsN(romCsN),
    .memRdN(memRdN),
    .memWrN(memWrN),
    .wrN(wrN),
    .width16(width16)
  );
endmodule

// File: rtl/romDecodeChecker.sv
module romDecodeChecker (
  input logic clk,
  input logic rstN,
  input logic cycValid,
  input logic cycWrite,
  input logic cfgFlashWrEn,
  input logic busDone,
  input logic claim,
  input logic romCsN,
  input logic memRdN,
  input logic memWrN,
  input logic wrN
);
  // R4/R6: an open chip select carries exactly one direction strobe
  assert_one_dir_R4: assert property (@(posedge clk) disable iff (!rstN)
    !romCsN |-> ($countones({!memRdN, !memWrN}) == 1));

  // R6: the two write strobes move as a pair
  assert_wr_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrN == wrN);

  // R4: claim lasts a single cycle and comes with chip select
  assert_claim_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    claim |=> !claim);
  assert_claim_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> !romCsN);

  // R5: a write without flash enable, seen while idle, opens nothing
  assert_no_unflashed_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycWrite && !cfgFlashWrEn && romCsN) |=> (romCsN && memWrN && !claim));

  // R8: hold until done, then release all together
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!romCsN && !busDone) |=> (!romCsN && $stable(memRdN) && $stable(memWrN)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!romCsN && busDone) |=> (romCsN && memRdN && memWrN && wrN));

  // R9: no new claim while a cycle is open
  assert_no_reclaim_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!romCsN && !busDone) |=> !claim);
endmodule

bind romRegionDecoder romDecodeChecker chk (
  .clk(clk),
  .rstN(rstN),
  .cycValid(cycValid),
  .cycWrite(cycWrite),
  .cfgFlashWrEn(cfgFlashWrEn),
  .busDone(busDone),
  .claim(claim),
  .romCsN(romCsN),
  .memRdN(memRdN),
  .memWrN(memWrN),
  .wrN(wrN)
);

// File: tb/romRegionDecoder_test.sv
module romRegionDecoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycValid = 1'b0;
  logic [31:0] cycAddr = '0;
  logic        cycWrite = 1'b0;
  logic        strapWide16 = 1'b1;
  logic        cfgBigWindow = 1'b0;
  logic        cfgWidthOvrEn = 1'b0;
  logic        cfgWidthOvr16 = 1'b0;
  logic        cfgFlashWrEn = 1'b0;
  logic        busDone = 1'b0;
  logic        claim, romCsN, memRdN, memWrN, wrN, width16;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  romRegionDecoder uut (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycAddr(cycAddr),
    .cycWrite(cycWrite), .strapWide16(strapWide16), .cfgBigWindow(cfgBigWindow),
    .cfgWidthOvrEn(cfgWidthOvrEn), .cfgWidthOvr16(cfgWidthOvr16),
    .cfgFlashWrEn(cfgFlashWrEn), .busDone(busDone), .claim(claim),
    .romCsN(romCsN), .memRdN(memRdN), .memWrN(memWrN), .wrN(wrN), .width16(width16)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Bus outputs packed as {claim, romCsN, memRdN, memWrN, wrN}
  function automatic logic [4:0] busOut(input logic c, cs, rd, wm, w);
    return {c, cs, rd, wm, w};
  endfunction

  function automatic bit expHit(input logic [31:0] a, input bit big);
    logic [32:0] lowLo, highLo;
    lowLo  = big ? 33'h0_000E_0000 : 33'h0_000F_0000;
    highLo = big ? 33'h0_FF00_0000 : 33'h0_FFFC_0000;
    return ({1'b0, a} >= lowLo && {1'b0, a} <= 33'h0_000F_FFFF) || ({1'b0, a} >= highLo);
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input bit strap);
    @(negedge clk);
    rstN = 1'b0;
    strapWide16 = strap;
    tick();
    tick();
    // R1: outputs idle while in reset
    check("R1 strobes in reset", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});
    check("R1 width in reset", {31'd0, width16}, 32'd0);
    rstN = 1'b1;
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input bit big, input bit flash);
    bit hit;
    bit go;
    string tag;
    hit = expHit(a, big);
    go  = hit && (!wr || flash);
    if (!hit)       tag = big ? "R3/R7" : "R2/R7";
    else if (!wr)   tag = big ? "R3/R4" : "R2/R4";
    else if (flash) tag = big ? "R3/R6" : "R2/R6";
    else            tag = big ? "R3/R5" : "R2/R5";
    cycAddr = a;
    cycWrite = wr;
    cfgBigWindow = big;
    cfgFlashWrEn = flash;
    cycValid = 1'b1;
    tick();
    cycValid = 1'b0;
    check(tag, {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(go, !go, !(go && !wr), !(go && wr), !(go && wr))});
    if (go) begin
      tick();
      check("R8 hold", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
            {27'd0, busOut(1'b0, 1'b0, wr, !wr, !wr)});
      busDone = 1'b1;
      tick();
      busDone = 1'b0;
      check("R8 release", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
            {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});
    end
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  logic [31:0] edgeList [12] = '{
    32'h0000_0000, 32'h000D_FFFF, 32'h000E_0000, 32'h000E_FFFF,
    32'h000F_0000, 32'h000F_FFFF, 32'h0010_0000, 32'hFEFF_FFFF,
    32'hFF00_0000, 32'hFFFB_FFFF, 32'hFFFC_0000, 32'hFFFF_FFFF};

  initial begin
    // R10: strap = 1 captured on the first edge after reset
    doReset(1'b1);
    @(negedge clk);
    check("R10 strap 1", {31'd0, width16}, 32'd1);
    strapWide16 = 1'b0;
    tick();
    tick();
    check("R10 strap change ignored", {31'd0, width16}, 32'd1);

    // R11: override
    cfgWidthOvr16 = 1'b0;
    cfgWidthOvrEn = 1'b1;
    tick();
    check("R11 override to 8", {31'd0, width16}, 32'd0);
    cfgWidthOvr16 = 1'b1;
    tick();
    check("R11 override to 16", {31'd0, width16}, 32'd1);
    cfgWidthOvr16 = 1'b0;
    tick();
    cfgWidthOvrEn = 1'b0;
    tick();
    check("R11 back to strap", {31'd0, width16}, 32'd1);

    // R10: second reset with strap = 0
    doReset(1'b0);
    @(negedge clk);
    check("R10 strap 0", {31'd0, width16}, 32'd0);
    strapWide16 = 1'b1;
    tick();
    check("R10 strap change ignored 2", {31'd0, width16}, 32'd0);

    // R7: no valid strobe, ROM address on the bus
    cycAddr = 32'hFFFF_FFF0;
    cycValid = 1'b0;
    tick();
    check("R7 no valid", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});

    // R8: done while idle has no effect
    busDone = 1'b1;
    tick();
    busDone = 1'b0;
    check("R8 idle done", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});

    // Sweeps over windows, operations and addresses (R2..R8)
    for (int big = 0; big < 2; big++) begin
      for (int op = 0; op < 3; op++) begin
        for (int e = 0; e < 12; e++)
          access(edgeList[e], op != 0, big[0], op == 2);
        for (int i = 0; i < 64; i++)
          access(32'(i) * 32'h0400_0000 + 32'(i) * 32'h0001_3579, op != 0, big[0], op == 2);
        for (int i = 0; i < 32; i++)
          access(32'h000D_8000 + 32'(i) * 32'h0000_1800, op != 0, big[0], op == 2);
        for (int i = 0; i < 32; i++)
          access(32'hFEFC_0000 + 32'(i) * 32'h0008_0000, op != 0, big[0], op == 2);
      end
    end

    // R9: new access while a read is open, then done
    cfgBigWindow = 1'b0;
    cfgFlashWrEn = 1'b1;
    cycAddr = 32'h000F_1234;
    cycWrite = 1'b0;
    cycValid = 1'b1;
    tick();
    cycAddr = 32'hFFFF_0000;
    cycWrite = 1'b1;
    tick();
    cycValid = 1'b0;
    check("R9 ignored while open", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b0, 1'b0, 1'b1, 1'b1)});
    cycValid = 1'b1;
    busDone = 1'b1;
    tick();
    busDone = 1'b0;
    cycValid = 1'b0;
    check("R9/R8 done with access pending", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});
    tick();
    check("R9 no late cycle", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});

    // R1: reset during an open cycle
    access(32'hFFFC_0000, 1'b0, 1'b0, 1'b0);
    cycAddr = 32'hFFFC_0000;
    cycWrite = 1'b0;
    cycValid = 1'b1;
    tick();
    cycValid = 1'b0;
    doReset(1'b1);
    @(negedge clk);
    check("R1 idle after reset", {27'd0, busOut(claim, romCsN, memRdN, memWrN, wrN)},
          {27'd0, busOut(1'b0, 1'b1, 1'b1, 1'b1, 1'b1)});
    finishRun();
  end
endmodule